// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block holds two 32-bit event counters, called upper and lower, and one 64-bit control word. Every cycle each counter looks at one event line chosen by its own select field. The counter advances by one when that line is high and the control word enables the processor's current privilege context. The three context enables and the interrupt enable apply to both counters together. So neither counter can be halted by itself: it is parked by selecting one of the reserved never-firing event codes.

Both counters are read and loaded through one 64-bit counter register. To sample every N events, software loads a counter with the 32-bit two's complement of N. After N increments the counter wraps from all ones to zero. The wrap latches that counter's overflow status bit. When the interrupt enable is set, the latched status drives a level interrupt.

Software clears the status by writing the control word with the interrupt enable set. Rewriting the value that is already there is enough.

The register port is a plain single-cycle interface and never applies back-pressure. A write takes effect at the clock edge where `reg_wr` is sampled high. Read data is combinational from `reg_addr`.

Top module: `perfmon_pair`

## Requirements
- R1: While reset is asserted and right after it, the control word, both counters, both status bits and `irq` are zero.
- R2: Address 1 is the counter register: upper counter in bits 63:32, lower counter in bits 31:0. A write loads both counters at the same clock edge.
- R3: A counter adds one at a clock edge only if its selected event is active and the enable for the current context is set. Context codes are 0 user, 1 supervisor, 2 hypervisor and 3 none, which never counts. Control bit 0 enables user, bit 1 supervisor and bit 2 hypervisor.
- R4: The lower select field is control bits 9:4 and the upper select field is bits 25:20. Code 0 counts every cycle. A code k from 1 to 61 follows `evt_vec[k]`, and `evt_vec[1]` is the retired-instruction pulse. Codes 62 and 63 never fire, whatever `evt_vec` holds.
- R5: A wrap from 0xFFFFFFFF to 0 caused by an increment sets that counter's status bit (`ovf_status[1]` upper, `ovf_status[0]` lower) at the same edge. A load through the counter register never sets it.
- R6: `irq` is high exactly when control bit 3 (interrupt enable) is set and at least one status bit is set.
- R7: A control write whose data has bit 3 set clears both status bits; a wrap at the same edge still sets its bit. A control write with bit 3 clear leaves the status unchanged.
- R8: A counter-register write at the same edge as an increment wins: the counter takes the written value.
- R9: Control bits outside 25:20, 9:4 and 3:0 read back as zero.
- R10: A counter loaded with the two's complement of N, counting every cycle, overflows on exactly the N-th increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = counter register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` |
| evt_vec | input | 64 | Per-cycle event pulses, one per select code |
| ctx | input | 2 | Current privilege context |
| ovf_status | output | 2 | Latched overflow bits (1 upper, 0 lower) |
| irq | output | 1 | Level overflow interrupt |

## Verification
Directed sequences drive cycle counting and sparse instruction pulses at the same time. This shows that the two select fields are decoded independently and not swapped. A sweep over contexts with only some enables set separates a correct per-context gate from a plain OR of the enables. Near-wrap loads, with and without the interrupt enable, and with a never-fire code on the other counter, separate overflow latching from interrupt gating and from idling. A long random phase mixes loads, control writes, context changes and event bursts, and compares every output against a behavioural model on every cycle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CNT_W    = 32;
  localparam int SEL_W    = 6;
  localparam int NUM_EVT  = 1 << SEL_W;
  localparam int REG_W    = 2 * CNT_W;
  localparam int NCNT     = 2;
  localparam int USR_BIT  = 0;
  localparam int SUP_BIT  = 1;
  localparam int HYP_BIT  = 2;
  localparam int IRQ_BIT  = 3;
  localparam int LO_SHIFT = 4;
  localparam int HI_SHIFT = 20;

  typedef enum logic [1:0] {
    CTX_USER  = 2'd0,
    CTX_SUPER = 2'd1,
    CTX_HYPER = 2'd2,
    CTX_NONE  = 2'd3
  } ctx_e;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W = 32,
  parameter int SEL_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld,
  input  logic [CNT_W-1:0]        ld_val,
  input  logic [SEL_W-1:0]        sel,
  input  logic [(1<<SEL_W)-1:0]   evt_vec,
  input  logic                    ctx_ok,
  output logic [CNT_W-1:0]        cnt,
  output logic                    wrap
);
  localparam int NUM_EVT = 1 << SEL_W;
  localparam logic [SEL_W-1:0] SEL_CYC = '0;
  localparam logic [SEL_W-1:0] IDLE_LO = SEL_W'(NUM_EVT - 2);

  logic [CNT_W-1:0] cnt_q;
  logic fire, inc;

  always_comb begin
    if (sel == SEL_CYC)      fire = 1'b1;
    else if (sel >= IDLE_LO) fire = 1'b0;
    else                     fire = evt_vec[sel];
  end

  assign inc  = ctx_ok & fire;
  assign wrap = inc & ~ld & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (ld)  cnt_q <= ld_val;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R2 R8
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(ld_val));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !ctx_ok) |=> $stable(cnt_q));

  // R4
  never_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && sel >= IDLE_LO) |=> $stable(cnt_q));
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int SEL_W = 6,
  parameter int NCNT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  ctx_e             ctx,
  input  logic [NCNT-1:0]  wrap,
  output logic [SEL_W-1:0] lo_sel,
  output logic [SEL_W-1:0] hi_sel,
  output logic             ctx_ok,
  output logic             any_en,
  output logic [REG_W-1:0] rdata,
  output logic [NCNT-1:0]  status,
  output logic             irq
);
  logic usr_q, sup_q, hyp_q, irqen_q;
  logic [SEL_W-1:0] lo_q, hi_q;
  logic [NCNT-1:0]  st_q;
  logic clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_q <= 1'b0; sup_q <= 1'b0; hyp_q <= 1'b0; irqen_q <= 1'b0;
      lo_q  <= '0;   hi_q  <= '0;
    end else if (wr) begin
      usr_q   <= wdata[USR_BIT];
      sup_q   <= wdata[SUP_BIT];
      hyp_q   <= wdata[HYP_BIT];
      irqen_q <= wdata[IRQ_BIT];
      lo_q    <= wdata[LO_SHIFT +: SEL_W];
      hi_q    <= wdata[HI_SHIFT +: SEL_W];
    end
  end

  assign clr = wr & wdata[IRQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (clr ? '0 : st_q) | wrap;
  end

  always_comb begin
    unique case (ctx)
      CTX_USER:  ctx_ok = usr_q;
      CTX_SUPER: ctx_ok = sup_q;
      CTX_HYPER: ctx_ok = hyp_q;
      default:   ctx_ok = 1'b0;
    endcase
  end

  always_comb begin
    rdata = '0;
    rdata[USR_BIT] = usr_q;
    rdata[SUP_BIT] = sup_q;
    rdata[HYP_BIT] = hyp_q;
    rdata[IRQ_BIT] = irqen_q;
    rdata[LO_SHIFT +: SEL_W] = lo_q;
    rdata[HI_SHIFT +: SEL_W] = hi_q;
  end

  assign any_en = usr_q | sup_q | hyp_q;
  assign lo_sel = lo_q;
  assign hi_sel = hi_q;
  assign status = st_q;
  assign irq    = irqen_q & (|st_q);

  for (genvar i = 0; i < NCNT; i++) begin : g_chk
    // R5
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q[i]) |-> $past(wrap[i]));
  end

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(|wrap)) |=> st_q == '0);

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rdata[IRQ_BIT] && st_q != '0));
endmodule

// File: rtl/perfmon_pair.sv
module perfmon_pair
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_EVT-1:0] evt_vec,
  input  logic [1:0]         ctx,
  output logic [NCNT-1:0]    ovf_status,
  output logic               irq
);
  logic [SEL_W-1:0] lo_sel, hi_sel;
  logic [SEL_W-1:0] sel_a [NCNT];
  logic [CNT_W-1:0] cnt_a [NCNT];
  logic [NCNT-1:0]  wrap;
  logic [REG_W-1:0] ctrl_rd;
  logic ctx_ok, any_en, cnt_wr, ctl_wr;

  assign cnt_wr = reg_wr &  reg_addr;
  assign ctl_wr = reg_wr & ~reg_addr;

  pmu_ctrl #(.REG_W(REG_W), .SEL_W(SEL_W), .NCNT(NCNT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(reg_wdata),
    .ctx(ctx_e'(ctx)), .wrap(wrap), .lo_sel(lo_sel), .hi_sel(hi_sel),
    .ctx_ok(ctx_ok), .any_en(any_en), .rdata(ctrl_rd),
    .status(ovf_status), .irq(irq)
  );

  assign sel_a[0] = lo_sel;
  assign sel_a[1] = hi_sel;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    pmu_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ld(cnt_wr),
      .ld_val(reg_wdata[i*CNT_W +: CNT_W]), .sel(sel_a[i]),
      .evt_vec(evt_vec), .ctx_ok(ctx_ok), .cnt(cnt_a[i]), .wrap(wrap[i])
    );
  end

  assign reg_rdata = reg_addr ? {cnt_a[1], cnt_a[0]} : ctrl_rd;

  // R3
  idle_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_en && !cnt_wr) |=> ($stable(cnt_a[0]) && $stable(cnt_a[1])));
endmodule

// File: tb/tb_perfmon_pair.sv
module tb_perfmon_pair;
  localparam logic [63:0] MASK = 64'h0000_0000_03F0_03FF;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr, reg_addr;
  logic [63:0] reg_wdata, reg_rdata, evt_vec;
  logic [1:0]  ctx, ovf_status;
  logic        irq;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_cnt [2];
  logic [63:0] m_ctrl;
  logic [1:0]  m_st;

  always #4 clk = ~clk;

  perfmon_pair dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_vec(evt_vec),
    .ctx(ctx), .ovf_status(ovf_status), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    reg_wr = 1'b0;
    reg_addr = 1'b0; #1;
    chk("R9 control readback", reg_rdata, m_ctrl);
    reg_addr = 1'b1; #1;
    chk("R3 counters", reg_rdata, {m_cnt[1], m_cnt[0]});
    chk("R5 status", {62'd0, ovf_status}, {62'd0, m_st});
    chk("R6 irq", {63'd0, irq}, {63'd0, (m_ctrl[3] && m_st != 2'b00)});
  endtask

  task automatic model_edge(input logic wr, input logic addr, input logic [63:0] wd,
                            input logic [63:0] ev, input logic [1:0] pv);
    logic ok;
    logic [1:0] wr_bits;
    logic [31:0] nc [2];
    case (pv)
      2'd0: ok = m_ctrl[0];
      2'd1: ok = m_ctrl[1];
      2'd2: ok = m_ctrl[2];
      default: ok = 1'b0;
    endcase
    wr_bits = 2'b00;
    for (int i = 0; i < 2; i++) begin
      int s;
      logic f;
      s = (i == 1) ? int'(m_ctrl[25:20]) : int'(m_ctrl[9:4]);
      if (s == 0) f = 1'b1;
      else if (s >= 62) f = 1'b0;
      else f = ev[s];
      nc[i] = m_cnt[i];
      if (wr && addr) nc[i] = wd[i*32 +: 32];
      else if (ok && f) begin
        wr_bits[i] = (m_cnt[i] == 32'hFFFF_FFFF);
        nc[i] = m_cnt[i] + 32'd1;
      end
    end
    m_cnt[0] = nc[0];
    m_cnt[1] = nc[1];
    if (wr && !addr) begin
      if (wd[3]) m_st = 2'b00;
      m_ctrl = wd & MASK;
    end
    m_st = m_st | wr_bits;
  endtask

  task automatic step(input logic wr, input logic addr, input logic [63:0] wd,
                      input logic [63:0] ev, input logic [1:0] pv);
    reg_wr = wr; reg_addr = addr; reg_wdata = wd; evt_vec = ev; ctx = pv;
    @(posedge clk);
    model_edge(wr, addr, wd, ev, pv);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic idle(input int n, input logic [63:0] ev, input logic [1:0] pv);
    for (int k = 0; k < n; k++) step(1'b0, 1'b1, 64'd0, ev, pv);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0; evt_vec = '0; ctx = 2'd0;
    m_cnt[0] = '0; m_cnt[1] = '0; m_ctrl = '0; m_st = '0;
    repeat (3) @(negedge clk);
    #1 chk("R1 control in reset", reg_rdata, 64'd0);
    reg_addr = 1'b1; #1;
    chk("R1 counters in reset", reg_rdata, 64'd0);
    chk("R1 status in reset", {62'd0, ovf_status}, 64'd0);
    chk("R1 irq in reset", {63'd0, irq}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all();

    // user only; lower counts cycles, upper counts instructions
    step(1'b1, 1'b0, 64'h0010_0001, 64'd0, 2'd0);
    for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 64'd0, (k % 3 == 0) ? 64'h2 : 64'h0, 2'd0);
    chk("R4 cycles vs instructions", reg_rdata, {32'd4, 32'd10});

    // contexts not enabled
    idle(3, '1, 2'd1);
    chk("R3 supervisor disabled", reg_rdata, {32'd4, 32'd10});
    step(1'b1, 1'b0, 64'h0010_0006, '1, 2'd1);
    idle(2, '1, 2'd2);
    idle(2, '1, 2'd0);
    idle(2, '1, 2'd3);
    chk("R3 hyper only counts", reg_rdata, {32'd6, 32'd12});

    // load beats increment
    step(1'b1, 1'b1, {32'h100, 32'h200}, '1, 2'd2);
    chk("R8 load wins", reg_rdata, {32'h100, 32'h200});
    chk("R2 layout", reg_rdata[63:32], 64'h100);

    // sample period 5 on lower; upper parked on code 63 at all ones
    step(1'b1, 1'b0, 64'h03F0_0009, '1, 2'd0);
    step(1'b1, 1'b1, {32'hFFFF_FFFF, 32'hFFFF_FFFB}, '1, 2'd0);
    chk("R5 load does not set status", {62'd0, ovf_status}, 64'd0);
    idle(4, '1, 2'd0);
    chk("R10 no overflow before N", {62'd0, ovf_status}, 64'd0);
    idle(1, '1, 2'd0);
    chk("R10 overflow at N", {62'd0, ovf_status}, 64'd1);
    chk("R4 code 63 never fires", reg_rdata, {32'hFFFF_FFFF, 32'd0});
    chk("R6 irq raised", {63'd0, irq}, 64'd1);

    // rewrite same control value
    step(1'b1, 1'b0, 64'h03F0_0009, '0, 2'd0);
    chk("R7 same-value write clears", {62'd0, ovf_status}, 64'd0);
    chk("R7 irq dropped", {63'd0, irq}, 64'd0);

    // upper wraps with interrupt disabled, lower parked on 62
    step(1'b1, 1'b0, 64'h0000_03E1, '0, 2'd0);
    step(1'b1, 1'b1, {32'hFFFF_FFFE, 32'd5}, '0, 2'd0);
    idle(2, '1, 2'd0);
    chk("R5 upper status", {62'd0, ovf_status}, 64'd2);
    chk("R6 irq gated off", {63'd0, irq}, 64'd0);
    chk("R4 code 62 never fires", reg_rdata[31:0], 64'd5);
    step(1'b1, 1'b0, 64'h0000_03E1, '0, 2'd0);
    chk("R7 write without enable keeps status", {62'd0, ovf_status}, 64'd2);
    step(1'b1, 1'b0, 64'h0000_03E8, '0, 2'd0);
    chk("R7 write with enable clears", {62'd0, ovf_status}, 64'd0);

    // reserved bits
    step(1'b1, 1'b0, '1, '0, 2'd0);
    reg_addr = 1'b0; #1;
    chk("R9 reserved read zero", reg_rdata, MASK);
    idle(3, '1, 2'd0);

    // random phase, compared every cycle
    for (int k = 0; k < 400; k++) begin
      logic wr, ad;
      logic [63:0] wd;
      wr = ($urandom_range(0, 5) == 0);
      ad = $urandom_range(0, 1);
      wd = {$urandom, $urandom};
      if (ad && $urandom_range(0, 1)) wd = {28'hFFFFFFF, wd[35:32], 28'hFFFFFFF, wd[3:0]};
      if (!ad) wd[25:20] = $urandom_range(0, 3) == 0 ? 6'd63 : 6'($urandom_range(0, 2));
      if (!ad) wd[9:4]   = $urandom_range(0, 3) == 0 ? 6'd62 : 6'($urandom_range(0, 2));
      step(wr, ad, wd, {$urandom, $urandom}, 2'($urandom_range(0, 3)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule